// File: doc/BRIEF.md
# Multi-address I2C slave receiver

This block is the target side of an I2C link, clocked by the system clock and watching the SCL and SDA pins through synchronizers. It responds to any of six programmable 7-bit addresses. After a START condition it shifts in an address byte and compares the upper seven bits against all six address slots in parallel. On a hit it acknowledges, raises an addressed flag and takes the transfer direction from bit 0 of the address byte. It then either receives data bytes, acknowledging each one only when enabled, or shifts out bytes supplied by the host logic and records the acknowledge bit that the controller returns.

SDA is open-drain. The block never drives a high level. It only asks for the line to be pulled low through `sda_pull_o`. The surrounding pad logic combines this request with the external line. When no slot matches, the block stays off the bus until the next START. A STOP condition ends the transaction and releases the bus.

Top module: `i2c_slave_maddr`

## Requirements
- R1: A START (SDA falling while SCL is high) sets `busy_o` and clears `addressed_o` and `dir_tx_o`. This also applies to a repeated START in the middle of a transfer. After reset `busy_o`, `addressed_o` and `sda_pull_o` are 0.
- R2: Bits are taken MSB first on each rising SCL edge. After the 8th bit of a received data byte, `rx_byte_o` holds the byte and `byte_done_o` pulses high for exactly one clock.
- R3: When the upper seven bits of the address byte equal any of the six slots, `addressed_o` is set after the 8th bit. The block also pulls SDA low for the 9th clock. Slot k occupies bits [7k+6:7k] of `slave_addr_i`.
- R4: When no slot matches, SDA is left released on the 9th clock and for every later clock until the next START, and no `byte_done_o` pulse occurs.
- R5: After a matching address, `dir_tx_o` equals bit 0 of the address byte. A value of 1 means the block transmits.
- R6: Every byte, address or data, takes exactly nine SCL pulses: eight data bits and one acknowledge.
- R7: While receiving data, SDA is pulled low on the 9th clock only if `ack_en_i` was 1 when the 8th bit arrived.
- R8: While transmitting, SDA is released on the 9th clock. The level sampled there is stored in `last_ack_o`, where 0 means ACK and 1 means NACK. A NACK ends transmission until the next START.
- R9: A STOP (SDA rising while SCL is high) clears `busy_o` and `addressed_o`.
- R10: While transmitting, the block shifts out `tx_byte_i` MSB first. It captures the byte at the 9th clock of the address byte and at each acknowledged 9th clock. A 0 bit is sent as a pull-low request on `sda_pull_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level (wired-AND line) |
| slave_addr_i | input | NUM_ADDR*ADDR_W | Six 7-bit address slots, slot 0 in the low bits |
| ack_en_i | input | 1 | Acknowledge received data bytes when 1 |
| tx_byte_i | input | ADDR_W+1 | Next byte to transmit |
| sda_pull_o | output | 1 | Request to pull SDA low |
| busy_o | output | 1 | Bus busy between START and STOP |
| addressed_o | output | 1 | Addressed as slave in this transaction |
| dir_tx_o | output | 1 | 1 = block transmits, 0 = block receives |
| rx_byte_o | output | ADDR_W+1 | Last received data byte |
| byte_done_o | output | 1 | One-cycle pulse per received data byte |
| last_ack_o | output | 1 | Acknowledge level returned by the controller |

## Verification
Each pin change reaches the internal edge detector after two synchronizer stages and one history stage. Every registered result therefore moves on the third clock edge after the pin change that caused it. The bench holds each SCL phase for 16 clocks and reads flags and the SDA line only near the middle or end of a phase, well after that three-edge delay. Received bytes are compared by a monitor on the falling clock edge whenever `byte_done_o` is high, against a queue that the driver fills before it sends each byte. Any pulse that arrives with an empty queue is counted as a failure.

// File: rtl/i2c_sl_pkg.sv
// Package: shared types for the multi-address I2C slave.
// Assumes: one byte is always eight bits plus one acknowledge slot.
package i2c_sl_pkg;
    // Protocol phase of the slave engine.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // not addressed or ignoring the bus
        ST_ADDR = 2'd1,  // receiving the address byte
        ST_RX   = 2'd2,  // receiving data bytes
        ST_TX   = 2'd3   // transmitting data bytes
    } sl_state_e;

    localparam int unsigned BITS_PER_BYTE = 8;
endpackage

// File: rtl/i2c_sl_sync.sv
// Module: i2c_sl_sync
// Passes each asynchronous bus line through a STAGES-deep flop chain,
// then keeps one more stage as history so edges can be detected.
// Assumes: lines idle high (open-drain bus), so reset loads ones.
module i2c_sl_sync #(
    parameter int unsigned LINES  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din_i,
    output logic [LINES-1:0] sync_o,
    output logic [LINES-1:0] prev_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] chain;
        // Shift the pin level through the synchronizer and history stage.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-1:0], din_i[g]};
        end
        assign sync_o[g] = chain[STAGES-1];
        assign prev_o[g] = chain[STAGES];
    end
endmodule

// File: rtl/i2c_sl_cond.sv
// Module: i2c_sl_cond
// Turns synchronized SCL/SDA levels and their one-cycle history into
// single-cycle events: SCL edges, START and STOP.
// Assumes: inputs come from i2c_sl_sync; START/STOP need SCL high in
// both the current and previous sample, so an SDA change that lands
// together with an SCL fall is not taken as a condition.
module i2c_sl_cond (
    input  logic scl_s,
    input  logic scl_p,
    input  logic sda_s,
    input  logic sda_p,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // Combinational event decode from current and previous samples.
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/i2c_sl_addr_match.sv
// Module: i2c_sl_addr_match
// Compares one received address against NUM_ADDR programmable slots
// at the same time and reports whether any slot hit.
// Assumes: slot k sits at bits [ADDR_W*k +: ADDR_W] of table_i.
module i2c_sl_addr_match #(
    parameter int unsigned NUM_ADDR = 6,
    parameter int unsigned ADDR_W   = 7
) (
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [NUM_ADDR*ADDR_W-1:0] table_i,
    output logic                       hit_o
);
    logic [NUM_ADDR-1:0] hit_vec;

    for (genvar k = 0; k < NUM_ADDR; k++) begin : g_slot
        assign hit_vec[k] = (table_i[ADDR_W*k +: ADDR_W] == addr_i);
    end

    // Any slot hitting counts as a match.
    assign hit_o = |hit_vec;
endmodule

// File: rtl/i2c_slave_maddr.sv
// Module: i2c_slave_maddr (top)
// I2C target engine answering to NUM_ADDR addresses. It detects
// START/STOP, shifts in the address byte, matches it, acknowledges,
// then receives or transmits data bytes with acknowledge handling.
// Assumes: SCL is much slower than clk (each SCL phase lasts at least
// four clk cycles); SDA is open-drain and sda_pull_o requests a low.
// Every result lags the pins by three clk edges (sync + history).
module i2c_slave_maddr
    import i2c_sl_pkg::*;
#(
    parameter int unsigned NUM_ADDR    = 6,
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    input  logic [NUM_ADDR*ADDR_W-1:0] slave_addr_i,
    input  logic                       ack_en_i,
    input  logic [ADDR_W:0]            tx_byte_i,
    output logic                       sda_pull_o,
    output logic                       busy_o,
    output logic                       addressed_o,
    output logic                       dir_tx_o,
    output logic [ADDR_W:0]            rx_byte_o,
    output logic                       byte_done_o,
    output logic                       last_ack_o
);
    localparam int unsigned BYTE_W = ADDR_W + 1;
    localparam int unsigned CNT_W  = $clog2(BITS_PER_BYTE + 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BITS_PER_BYTE);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS_PER_BYTE - 1);

    logic [1:0] pins_s, pins_p;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_det, stop_det;
    logic       hit;

    sl_state_e         st_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] sh_next;
    logic [BYTE_W-1:0] tx_sh;
    logic              ack_pend;

    i2c_sl_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  ({scl_i, sda_i}),
        .sync_o (pins_s),
        .prev_o (pins_p)
    );

    assign scl_s = pins_s[1];
    assign sda_s = pins_s[0];

    i2c_sl_cond u_cond (
        .scl_s     (pins_s[1]),
        .scl_p     (pins_p[1]),
        .sda_s     (pins_s[0]),
        .sda_p     (pins_p[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // Byte as it will stand once the current SDA sample is shifted in.
    assign sh_next = {sh_q[BYTE_W-2:0], sda_s};

    i2c_sl_addr_match #(.NUM_ADDR(NUM_ADDR), .ADDR_W(ADDR_W)) u_match (
        .addr_i  (sh_next[BYTE_W-1:1]),
        .table_i (slave_addr_i),
        .hit_o   (hit)
    );

    // Protocol engine: conditions first, then SCL rise/fall actions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            bit_cnt     <= '0;
            sh_q        <= '0;
            tx_sh       <= '0;
            ack_pend    <= 1'b0;
            sda_pull_o  <= 1'b0;
            busy_o      <= 1'b0;
            addressed_o <= 1'b0;
            dir_tx_o    <= 1'b0;
            rx_byte_o   <= '0;
            byte_done_o <= 1'b0;
            last_ack_o  <= 1'b0;
        end else begin
            byte_done_o <= 1'b0;
            if (start_det) begin
                st_q        <= ST_ADDR;
                bit_cnt     <= '0;
                ack_pend    <= 1'b0;
                sda_pull_o  <= 1'b0;
                busy_o      <= 1'b1;
                addressed_o <= 1'b0;
                dir_tx_o    <= 1'b0;
            end else if (stop_det) begin
                st_q        <= ST_IDLE;
                bit_cnt     <= '0;
                ack_pend    <= 1'b0;
                sda_pull_o  <= 1'b0;
                busy_o      <= 1'b0;
                addressed_o <= 1'b0;
            end else if (scl_rise) begin
                case (st_q)
                    ST_ADDR: begin
                        if (bit_cnt != ACK_SLOT) begin
                            sh_q    <= sh_next;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) begin
                                if (hit) begin
                                    addressed_o <= 1'b1;
                                    dir_tx_o    <= sda_s;
                                    ack_pend    <= 1'b1;
                                end else begin
                                    st_q <= ST_IDLE;
                                end
                            end
                        end else begin
                            bit_cnt  <= '0;
                            ack_pend <= 1'b0;
                            if (dir_tx_o) begin
                                st_q  <= ST_TX;
                                tx_sh <= tx_byte_i;
                            end else begin
                                st_q <= ST_RX;
                            end
                        end
                    end
                    ST_RX: begin
                        if (bit_cnt != ACK_SLOT) begin
                            sh_q    <= sh_next;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) begin
                                rx_byte_o   <= sh_next;
                                byte_done_o <= 1'b1;
                                ack_pend    <= ack_en_i;
                            end
                        end else begin
                            bit_cnt  <= '0;
                            ack_pend <= 1'b0;
                        end
                    end
                    ST_TX: begin
                        if (bit_cnt != ACK_SLOT) begin
                            tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else begin
                            bit_cnt    <= '0;
                            last_ack_o <= sda_s;
                            if (sda_s) st_q  <= ST_IDLE;
                            else       tx_sh <= tx_byte_i;
                        end
                    end
                    default: ;
                endcase
            end else if (scl_fall) begin
                case (st_q)
                    ST_ADDR, ST_RX: sda_pull_o <= (bit_cnt == ACK_SLOT) && ack_pend;
                    ST_TX:          sda_pull_o <= (bit_cnt != ACK_SLOT) && !tx_sh[BYTE_W-1];
                    default:        sda_pull_o <= 1'b0;
                endcase
            end
        end
    end

    // ---------------- assertions ----------------
    // R1: a START leaves the bus busy with addressing and direction cleared.
    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> busy_o && !addressed_o && !dir_tx_o);

    // R2: the byte-done strobe lasts one cycle.
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done_o |=> !byte_done_o);

    // R3: a hit on the last address bit marks the block as addressed.
    p_match_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ADDR && !start_det && !stop_det && scl_rise &&
         bit_cnt == LAST_BIT && hit) |=> addressed_o);

    // R4: while ignoring the bus the block never pulls SDA.
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> !sda_pull_o);

    // R5: direction is the last address bit sampled when addressing succeeds.
    p_dir_bit0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addressed_o) |-> (dir_tx_o == $past(sda_s)));

    // R6: a byte never takes more than nine SCL pulses.
    p_nine_pulses_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= ACK_SLOT);

    // R7: with acknowledge disabled, the receive ack slot stays released.
    p_rx_ack_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RX && scl_fall && bit_cnt == ACK_SLOT && !ack_pend) |=> !sda_pull_o);

    // R8: while transmitting, SDA is released for the controller's ack.
    p_tx_ack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TX && scl_fall && bit_cnt == ACK_SLOT) |=> !sda_pull_o);

    // R9: a STOP releases the bus and drops the addressed flag.
    p_stop_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !busy_o && !addressed_o);

    // R10: pull requests only change right after an SCL edge or condition.
    p_pull_on_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(scl_fall) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_pull_o));
endmodule

// File: tb/i2c_slave_maddr_tb.sv
module i2c_slave_maddr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 16;
    localparam int NUM_ADDR   = 6;
    localparam int ADDR_W     = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [NUM_ADDR*ADDR_W-1:0] slave_addr;
    logic ack_en = 1'b1;
    logic [7:0] tx_byte = 8'h00;
    logic sda_pull, busy, addressed, dir_tx, byte_done, last_ack;
    logic [7:0] rx_byte;
    wire sda_line = sda_m & ~sda_pull;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_slave_maddr #(.NUM_ADDR(NUM_ADDR), .ADDR_W(ADDR_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .slave_addr_i (slave_addr),
        .ack_en_i     (ack_en),
        .tx_byte_i    (tx_byte),
        .sda_pull_o   (sda_pull),
        .busy_o       (busy),
        .addressed_o  (addressed),
        .dir_tx_o     (dir_tx),
        .rx_byte_o    (rx_byte),
        .byte_done_o  (byte_done),
        .last_ack_o   (last_ack)
    );

    function automatic logic [6:0] slot_addr(input int k);
        return 7'((k + 1) * 18);
    endfunction

    initial begin
        for (int k = 0; k < NUM_ADDR; k++) slave_addr[ADDR_W*k +: ADDR_W] = slot_addr(k);
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: scoreboard of received data bytes (R2).
    always @(negedge clk) begin
        if (rst_n && byte_done) begin
            if (exp_q.size() == 0) check("R2/R4 unexpected byte_done", rx_byte, 'hFFFF);
            else check("R2 rx_byte", rx_byte, exp_q.pop_front());
        end
    end

    task automatic send_start();
        sda_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b0; wait_clk(HALF);
    endtask

    task automatic send_stop();
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b1; wait_clk(HALF);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b0; wait_clk(4);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF/2);
        b = sda_line; wait_clk(HALF/2);
        scl_m = 1'b0; wait_clk(4);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        get_bit(ack);
    endtask

    task automatic read_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
    endtask

    initial begin
        logic ack;
        logic [7:0] rd;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        check("R1 reset busy", busy, 0);
        check("R1 reset addressed", addressed, 0);
        check("R1 reset pull", sda_pull, 0);

        // Write to slot 0 with acknowledged data.
        send_start();
        check("R1 start busy", busy, 1);
        check("R1 start dir", dir_tx, 0);
        send_byte({slot_addr(0), 1'b0}, ack);
        check("R3 slot0 ack", ack, 0);
        check("R3 slot0 addressed", addressed, 1);
        check("R5 write dir", dir_tx, 0);
        ack_en = 1'b1;
        exp_q.push_back(8'hA5);
        send_byte(8'hA5, ack);
        check("R7 ack enabled", ack, 0);
        exp_q.push_back(8'h3C);
        send_byte(8'h3C, ack);
        check("R6 second byte ack", ack, 0);
        ack_en = 1'b0;
        exp_q.push_back(8'h81);
        send_byte(8'h81, ack);
        check("R7 ack disabled", ack, 1);
        ack_en = 1'b1;
        send_stop();
        check("R9 stop busy", busy, 0);
        check("R9 stop addressed", addressed, 0);

        // Address that hits no slot.
        send_start();
        send_byte({7'h11, 1'b0}, ack);
        check("R4 nomatch ack", ack, 1);
        check("R4 nomatch addressed", addressed, 0);
        send_byte(8'h00, ack);
        check("R4 ignored byte ack", ack, 1);
        send_stop();

        // Every other slot answers.
        for (int k = 1; k < NUM_ADDR; k++) begin
            send_start();
            send_byte({slot_addr(k), 1'b0}, ack);
            check("R3 slot ack", ack, 0);
            check("R3 slot addressed", addressed, 1);
            send_stop();
        end

        // Read from slot 5.
        tx_byte = 8'h96;
        send_start();
        send_byte({slot_addr(5), 1'b1}, ack);
        check("R3 read ack", ack, 0);
        check("R5 read dir", dir_tx, 1);
        read_byte(rd);
        check("R10 first tx byte", rd, 8'h96);
        tx_byte = 8'h5A;
        send_bit(1'b0);
        check("R8 last_ack ack", last_ack, 0);
        read_byte(rd);
        check("R10 second tx byte", rd, 8'h5A);
        send_bit(1'b1);
        check("R8 last_ack nack", last_ack, 1);
        get_bit(ack);
        check("R8 released after nack", ack, 1);
        send_stop();
        check("R9 stop after read", busy, 0);

        // Repeated start clears direction.
        tx_byte = 8'hF0;
        send_start();
        send_byte({slot_addr(2), 1'b1}, ack);
        check("R5 dir before restart", dir_tx, 1);
        send_start();
        check("R1 restart dir", dir_tx, 0);
        check("R1 restart busy", busy, 1);
        send_byte({slot_addr(2), 1'b0}, ack);
        check("R3 restart ack", ack, 0);
        send_stop();

        wait_clk(4);
        check("R2 scoreboard drained", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule